// File: doc/BRIEF.md
# Pulse Swallow Dual Modulus Divider

This block divides a stream of input events by a programmable ratio of 64·N + A. A dual modulus prescaler counts input events in groups of 65 or 64. A swallow counter, loaded with A, keeps the prescaler in its 65 mode for the first A groups of each output period. A program counter, loaded with N, ends the period after N groups. A one-cycle pulse on `fp` marks the end of each period. A separate reference counter divides a second event stream by R and pulses `fr`. The two outputs feed a phase comparator.

Both streams are single-cycle strobes that are sampled on the block clock. Cycles without a strobe do not count. New A, N and R values are picked up when the matching counter reaches its terminal count, so a period that is already running keeps its ratio. A resync request restarts both dividers together, so that `fp` and `fr` begin a new period in phase.

Top module: `dual_mod_divider`

## Requirements
- R1: During synchronous reset and after it, `fp` and `fr` are low. The counters are loaded from the configuration inputs, so `mod_hi` is high exactly when `cfg_swallow` is nonzero.
- R2: With A < N, `fp` is high for one cycle. That cycle follows the clock edge that samples the (64·N + A)-th `vco_tick` since the previous `fp` or restart. Cycles with `vco_tick` low are not counted, and they never produce `fp`.
- R3: With A < N, `mod_hi` is high during exactly 65·A of the counted ticks of each period, namely the first A prescaler groups. It is low for the rest of the period. It changes only after a sampled tick or a restart.
- R4: With A ≥ N, every prescaler group divides by 65. The period is then 65·N ticks, and `mod_hi` is high for all of them.
- R5: `fr` is high for one cycle after every R-th sampled `ref_tick`. Cycles with `ref_tick` low never produce `fr`.
- R6: A change of `cfg_swallow`, `cfg_prog` or `cfg_ref` in the middle of a period does not alter that period. The new value applies from the next period.
- R7: A sampled `resync` reloads the prescaler, swallow, program and reference counters from the configuration inputs and discards partial counts. `fp` and `fr` are low in the next cycle. Both dividers then run full periods, so equal ratios produce `fp` and `fr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| vco_tick | input | 1 | Input event strobe for the main divider |
| ref_tick | input | 1 | Reference event strobe |
| resync | input | 1 | Restarts both dividers in phase |
| cfg_swallow | input | 6 | Swallow count A |
| cfg_prog | input | 12 | Program count N |
| cfg_ref | input | 14 | Reference ratio R |
| fp | output | 1 | Divided main pulse |
| fr | output | 1 | Divided reference pulse |
| mod_hi | output | 1 | Prescaler modulus select: 1 selects 65, 0 selects 64 |

## Verification
The hardest case to reach from the ports is the boundary at which a period is already under way while its configuration changes or a restart arrives. At that point the counters hold values that cannot be seen directly. The stimulus changes A and N, or asserts resync, a known number of ticks into a period. The scoreboard then expects the old ratio for the running period, or a full new period after the restart, measured in counted ticks and in ticks with `mod_hi` high. Gapped tick patterns, the edge values of A and N, a large R and a coincident restart of both dividers complete the stimulus.

// File: rtl/dual_mod_divider.sv
module dual_mod_divider #(
  parameter int PRE_MOD = 64,
  parameter int A_W     = 6,
  parameter int N_W     = 12,
  parameter int R_W     = 14
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           vco_tick,
  input  logic           ref_tick,
  input  logic           resync,
  input  logic [A_W-1:0] cfg_swallow,
  input  logic [N_W-1:0] cfg_prog,
  input  logic [R_W-1:0] cfg_ref,
  output logic           fp,
  output logic           fr,
  output logic           mod_hi
);
  localparam int PW = $clog2(PRE_MOD + 1);

  logic [PW-1:0]  pre_cnt;
  logic [A_W-1:0] sw_cnt;
  logic [N_W-1:0] pg_cnt;
  logic [R_W-1:0] ref_cnt;

  wire restart = rst | resync;

  assign mod_hi = (sw_cnt != '0);

  wire [PW-1:0] pre_last = mod_hi ? PW'(PRE_MOD) : PW'(PRE_MOD - 1);
  wire          pre_evt  = vco_tick && (pre_cnt == pre_last);
  wire          prog_tc  = pre_evt && (pg_cnt <= N_W'(1));
  wire          ref_tc   = ref_tick && (ref_cnt <= R_W'(1));

  always_ff @(posedge clk) begin
    if (restart) begin
      pre_cnt <= '0;
      sw_cnt  <= cfg_swallow;
      pg_cnt  <= cfg_prog;
      fp      <= 1'b0;
    end else begin
      fp <= prog_tc;
      if (vco_tick)
        pre_cnt <= pre_evt ? '0 : pre_cnt + 1'b1;
      if (prog_tc) begin
        sw_cnt <= cfg_swallow;
        pg_cnt <= cfg_prog;
      end else if (pre_evt) begin
        pg_cnt <= pg_cnt - 1'b1;
        if (mod_hi)
          sw_cnt <= sw_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (restart) begin
      ref_cnt <= cfg_ref;
      fr      <= 1'b0;
    end else begin
      fr <= ref_tc;
      if (ref_tc)
        ref_cnt <= cfg_ref;
      else if (ref_tick)
        ref_cnt <= ref_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/dual_mod_divider_chk.sv
module dual_mod_divider_chk (
  input logic clk,
  input logic rst,
  input logic vco_tick,
  input logic ref_tick,
  input logic resync,
  input logic fp,
  input logic fr,
  input logic mod_hi
);
  p_fp_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!vco_tick && !resync) |=> !fp);

  p_fp_single_r2: assert property (@(posedge clk) disable iff (rst)
    fp |=> !fp);

  p_mod_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!vco_tick && !resync) |=> $stable(mod_hi));

  p_fr_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (!ref_tick && !resync) |=> !fr);

  p_fr_single_r5: assert property (@(posedge clk) disable iff (rst)
    fr |=> !fr);

  p_resync_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    resync |=> (!fp && !fr));
endmodule

bind dual_mod_divider dual_mod_divider_chk chk_i (
  .clk(clk), .rst(rst), .vco_tick(vco_tick), .ref_tick(ref_tick),
  .resync(resync), .fp(fp), .fr(fr), .mod_hi(mod_hi)
);

// File: tb/dual_mod_divider_tb_top.sv
module dual_mod_divider_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vco_tick = 1'b0, ref_tick = 1'b0, resync = 1'b0;
  logic [5:0]  cfg_swallow = 6'd3;
  logic [11:0] cfg_prog = 12'd5;
  logic [13:0] cfg_ref = 14'd5;
  logic fp, fr, mod_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_mod_divider dut_i (
    .clk(clk), .rst(rst), .vco_tick(vco_tick), .ref_tick(ref_tick),
    .resync(resync), .cfg_swallow(cfg_swallow), .cfg_prog(cfg_prog),
    .cfg_ref(cfg_ref), .fp(fp), .fr(fr), .mod_hi(mod_hi)
  );

  int n_checks = 0, n_fail = 0;
  int exp_fp_t[$], exp_fp_h[$], exp_fr[$];
  string fp_tag[$], fr_tag[$];
  int vcnt = 0, hcnt = 0, rcnt = 0, both_seen = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_fp(input int a, input int n, input string tag);
    if (a < n) begin
      exp_fp_t.push_back(64*n + a);
      exp_fp_h.push_back(65*a);
    end else begin
      exp_fp_t.push_back(65*n);
      exp_fp_h.push_back(65*n);
    end
    fp_tag.push_back(tag);
  endtask

  task automatic push_fr(input int r, input string tag);
    exp_fr.push_back(r);
    fr_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (fp) begin
        if (exp_fp_t.size() == 0) chk(1'b0, "R2 unexpected fp", 1, 0);
        else begin
          int et, eh;
          string tg;
          et = exp_fp_t.pop_front();
          eh = exp_fp_h.pop_front();
          tg = fp_tag.pop_front();
          chk(vcnt == et, {tg, " fp period ticks"}, vcnt, et);
          chk(hcnt == eh, {tg, " R3 mod_hi ticks"}, hcnt, eh);
        end
        vcnt = 0; hcnt = 0;
      end
      if (fr) begin
        if (exp_fr.size() == 0) chk(1'b0, "R5 unexpected fr", 1, 0);
        else begin
          int er;
          string tg;
          er = exp_fr.pop_front();
          tg = fr_tag.pop_front();
          chk(rcnt == er, {tg, " fr period ticks"}, rcnt, er);
        end
        rcnt = 0;
      end
      if (fp && fr) both_seen++;
      if (resync) begin
        vcnt = 0; hcnt = 0; rcnt = 0;
      end else begin
        if (vco_tick) begin
          vcnt++;
          if (mod_hi) hcnt++;
        end
        if (ref_tick) rcnt++;
      end
    end
  end

  task automatic run_vco(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      vco_tick = 1'b1;
      @(posedge clk); #1;
      vco_tick = 1'b0;
      for (int g = 0; g < (i % (gap + 1)); g++) begin
        @(posedge clk); #1;
      end
    end
  endtask

  task automatic run_ref(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      ref_tick = 1'b1;
      @(posedge clk); #1;
      ref_tick = 1'b0;
      for (int g = 0; g < (i % (gap + 1)); g++) begin
        @(posedge clk); #1;
      end
    end
  endtask

  task automatic run_both(input int n);
    for (int i = 0; i < n; i++) begin
      vco_tick = 1'b1; ref_tick = 1'b1;
      @(posedge clk); #1;
    end
    vco_tick = 1'b0; ref_tick = 1'b0;
  endtask

  task automatic do_resync();
    resync = 1'b1;
    @(posedge clk); #1;
    resync = 1'b0;
    @(negedge clk);
    chk(!fp && !fr, "R7 outputs low after resync", {fp, fr}, 0);
    @(posedge clk); #1;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(fp == 1'b0 && fr == 1'b0, "R1 outputs low in reset", {fp, fr}, 0);
    chk(mod_hi == 1'b1, "R1 mod_hi with A=3", mod_hi, 1);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk(mod_hi == 1'b1 && fp == 1'b0, "R1 state after reset release", mod_hi, 1);
    @(posedge clk); #1;

    push_fp(3, 5, "R2 a3n5");
    push_fp(3, 5, "R2 a3n5");
    run_vco(646, 0);
    settle();

    cfg_swallow = 6'd0; cfg_prog = 12'd5;
    do_resync();
    @(negedge clk);
    chk(mod_hi == 1'b0, "R1 mod_hi low with A=0", mod_hi, 0);
    @(posedge clk); #1;
    push_fp(0, 5, "R2 gapped");
    push_fp(0, 5, "R2 gapped");
    run_vco(640, 2);
    settle();

    cfg_swallow = 6'd63; cfg_prog = 12'd64;
    do_resync();
    push_fp(63, 64, "R3 a63n64");
    run_vco(4159, 1);
    settle();

    cfg_swallow = 6'd10; cfg_prog = 12'd5;
    do_resync();
    push_fp(10, 5, "R4 a10n5");
    push_fp(10, 5, "R4 a10n5");
    run_vco(650, 0);
    settle();

    cfg_swallow = 6'd3; cfg_prog = 12'd5;
    do_resync();
    push_fp(3, 5, "R6 old ratio");
    push_fp(1, 6, "R6 new ratio");
    run_vco(100, 0);
    cfg_swallow = 6'd1; cfg_prog = 12'd6;
    run_vco(608, 1);
    settle();

    run_vco(150, 0);
    do_resync();
    push_fp(1, 6, "R7 after mid resync");
    run_vco(385, 0);
    settle();

    cfg_ref = 14'd5;
    do_resync();
    push_fr(5, "R5 r5"); push_fr(5, "R5 r5"); push_fr(5, "R5 r5");
    run_ref(15, 2);
    settle();

    cfg_ref = 14'd16383;
    do_resync();
    push_fr(16383, "R5 r16383");
    run_ref(16383, 0);
    settle();

    cfg_ref = 14'd9;
    do_resync();
    push_fr(9, "R6 ref old");
    push_fr(7, "R6 ref new");
    run_ref(4, 0);
    cfg_ref = 14'd7;
    run_ref(12, 0);
    settle();

    run_ref(3, 0);
    do_resync();
    push_fr(7, "R7 ref after resync");
    run_ref(7, 0);
    settle();

    cfg_swallow = 6'd0; cfg_prog = 12'd5; cfg_ref = 14'd320;
    do_resync();
    both_seen = 0;
    push_fp(0, 5, "R7 aligned fp");
    push_fr(320, "R7 aligned fr");
    run_both(320);
    settle();
    chk(both_seen == 1, "R7 fp and fr coincide", both_seen, 1);

    chk(exp_fp_t.size() == 0, "R2 fp pulses pending", exp_fp_t.size(), 0);
    chk(exp_fr.size() == 0, "R5 fr pulses pending", exp_fr.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule